// File: doc/BRIEF.md
# Slow-Clock Timer Bridge

This block holds an 8-bit up-counter that runs on its own slow clock and makes it reachable from a processor on a separate, faster clock. The processor never samples the live counter. It reads a copy held in its own domain, and that copy is reloaded after every rising edge of the slow clock. Writes to the two compare registers and the two control registers land first in a staging register on the processor side. A busy bit is set for each staged register until the timer side has taken the value and sent an acknowledge back.

Overflow and the two compare matches are timer-side events. Each one travels to the processor clock as a toggle and sets a sticky flag there. The flags, a three-bit enable register and a global enable input together form the interrupt request. On the timer clock, a match can toggle an output pin directly, and every event produces a one-cycle wake pulse on the next timer cycle. To model sleep, the processor clock is simply stopped. The counter continues while it is stopped, and the processor-side copy goes stale.

Top module: `async_tmr_bridge`

## Requirements
- R1: After reset every readable register (addresses 0 to 7) reads zero, and irq_o, pin_a_o and pin_b_o are low.
- R2: While the run bit (bit 0 of the control register at address 3) is one, the counter advances by exactly one per rising timer-clock edge, wrapping modulo 256. A read of address 0 returns that count after each edge.
- R3: After the processor clock has been stopped and restarted, reads of address 0 return the value held before the stop until a timer edge has been carried across. After that they return the current count.
- R4: Writing address 1 (compare A), 2 (compare B), 3 (control A) or 4 (control B) sets busy bit 0, 1, 2 or 3 of address 7, respectively. The bit clears on its own once the value has reached the timer side.
- R5: A write to a register whose busy bit is set is ignored: the register keeps the earlier value.
- R6: The enable register at address 5 holds overflow (bit 0), compare A (bit 1) and compare B (bit 2). Bits 7 to 3 read as zero.
- R7: When the counter steps onto the compare A or compare B value, flag bit 1 or bit 2 of address 6 is set. The flag becomes visible in the same processor cycle as the shadow count that equals the compare value.
- R8: When the count wraps from 255 to 0, flag bit 0 of address 6 is set. At the moment the flag is visible, address 0 reads 0.
- R9: Writing a one to a bit of address 6 clears that flag. If a set arrives in the same processor cycle, the set wins.
- R10: irq_o is high exactly when gie_i is one and at least one flag has its enable bit set.
- R11: With control A bit 1 (or control B bit 0) set, pin_a_o (or pin_b_o) toggles on the timer edge of a compare A (or B) match.
- R12: wake_o is high for one timer cycle, beginning on the timer edge after the edge that produced an overflow or a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock; stopped to model sleep |
| tmr_clk | input | 1 | Independent slow timer clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe (processor clock) |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake pulse on the timer clock |
| pin_a_o | output | 1 | Compare A output pin (timer clock) |
| pin_b_o | output | 1 | Compare B output pin (timer clock) |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same processor cycle as the synchronized set from a new match. The stimulus first reads the shadow count once per timer period until it shows one below the compare value. It then waits for the next timer edge, counts two processor rising edges, and issues the clear so that it meets the third edge, which is where the set lands. A second difficult case is the stale read after a stopped processor clock. The bench stops its own clock across five timer edges and reads address 0 before the three-stage synchronizer has caught up.

// File: rtl/atb_pkg.sv
package atb_pkg;
  typedef enum logic [2:0] {
    A_CNT  = 3'd0,
    A_CMPA = 3'd1,
    A_CMPB = 3'd2,
    A_CTLA = 3'd3,
    A_CTLB = 3'd4,
    A_MASK = 3'd5,
    A_FLAG = 3'd6,
    A_BUSY = 3'd7
  } reg_addr_e;

  localparam int unsigned NFLAG   = 3;
  localparam int unsigned FL_OVF  = 0;
  localparam int unsigned FL_CMPA = 1;
  localparam int unsigned FL_CMPB = 2;
  localparam int unsigned CTLA_RUN = 0;
  localparam int unsigned CTLA_TGA = 1;
  localparam int unsigned NBUSY   = 4;
endpackage

// File: rtl/atb_toggle_sync.sv
module atb_toggle_sync #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  localparam int unsigned NST = SYNC + 1;
  logic [NST-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[NST-2:0], tgl_i};
  end

  // a change of the source toggle, seen after SYNC flops
  assign pulse_o = stg_q[NST-1] ^ stg_q[NST-2];
endmodule

// File: rtl/atb_wr_xfer.sv
module atb_wr_xfer #(
  parameter int unsigned W = 8
) (
  input  logic         cpu_clk,
  input  logic         tmr_clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stage_o,
  output logic         busy_o,
  output logic [W-1:0] dst_o
);
  logic [W-1:0] stage_q, dst_q;
  logic busy_q, req_q, ack_q;
  logic take, land, done;

  assign take = wr_i && !busy_q;

  atb_toggle_sync u_req (.clk_i(tmr_clk), .rst_ni(rst_n), .tgl_i(req_q), .pulse_o(land));
  atb_toggle_sync u_ack (.clk_i(cpu_clk), .rst_ni(rst_n), .tgl_i(ack_q), .pulse_o(done));

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
    end else if (take) begin
      stage_q <= wdata_i;
      busy_q  <= 1'b1;
      req_q   <= ~req_q;
    end else if (done) begin
      busy_q  <= 1'b0;
    end
  end

  // stage_q is frozen while busy, so the wide capture is safe
  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      ack_q <= 1'b0;
    end else if (land) begin
      dst_q <= stage_q;
      ack_q <= ~ack_q;
    end
  end

  assign stage_o = stage_q;
  assign busy_o  = busy_q;
  assign dst_o   = dst_q;

  a_r4_busy_on_write: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    take |=> busy_q);
  a_r5_busy_write_dropped: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (wr_i && busy_q) |=> $stable(stage_q));
endmodule

// File: rtl/atb_tmr_core.sv
module atb_tmr_core #(
  parameter int unsigned CW = 8
) (
  input  logic          tmr_clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tga_i,
  input  logic          tgb_i,
  input  logic [CW-1:0] cmpa_i,
  input  logic [CW-1:0] cmpb_i,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_tgl_o,
  output logic [2:0]    ev_tgl_o,
  output logic          pin_a_o,
  output logic          pin_b_o,
  output logic          wake_o
);
  import atb_pkg::*;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic wraps(input logic [CW-1:0] c);
    return c == {CW{1'b1}};
  endfunction

  logic [CW-1:0] cnt_q, nxt;
  logic [2:0]    ev, ev_tgl_q;
  logic          cnt_tgl_q, pa_q, pb_q, ev_q, wake_q;
  logic          ev_any;

  assign nxt = step(cnt_q);
  assign ev[FL_OVF]  = run_i && wraps(cnt_q);
  assign ev[FL_CMPA] = run_i && (nxt == cmpa_i);
  assign ev[FL_CMPB] = run_i && (nxt == cmpb_i);
  assign ev_any = |ev;

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_tgl_q <= 1'b0;
      ev_tgl_q  <= '0;
      pa_q      <= 1'b0;
      pb_q      <= 1'b0;
      ev_q      <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      cnt_tgl_q <= ~cnt_tgl_q;
      if (run_i) cnt_q <= nxt;
      ev_tgl_q  <= ev_tgl_q ^ ev;
      pa_q      <= pa_q ^ (ev[FL_CMPA] & tga_i);
      pb_q      <= pb_q ^ (ev[FL_CMPB] & tgb_i);
      ev_q      <= ev_any;
      wake_q    <= ev_q;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_tgl_o = cnt_tgl_q;
  assign ev_tgl_o  = ev_tgl_q;
  assign pin_a_o   = pa_q;
  assign pin_b_o   = pb_q;
  assign wake_o    = wake_q;

  a_r8_wrap_to_zero: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    ev[FL_OVF] |=> (cnt_q == '0));
  a_r11_pin_a_toggles: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (ev[FL_CMPA] && tga_i) |=> (pa_q != $past(pa_q)));
  a_r12_wake_next_cycle: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    ev_any |-> ##2 wake_o);
endmodule

// File: rtl/async_tmr_bridge.sv
module async_tmr_bridge #(
  parameter int unsigned CW = 8
) (
  input  logic          cpu_clk,
  input  logic          tmr_clk,
  input  logic          rst_n,
  input  logic          gie_i,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rd_data_o,
  output logic          irq_o,
  output logic          wake_o,
  output logic          pin_a_o,
  output logic          pin_b_o
);
  import atb_pkg::*;

  logic [CW-1:0] cmpa_stg, cmpb_stg, cmpa_t, cmpb_t, cnt_t, shadow_q;
  logic [1:0]    ctla_stg, ctla_t;
  logic          ctlb_stg, ctlb_t;
  logic [NBUSY-1:0] busy;
  logic [NFLAG-1:0] ev_tgl, fl_set, fl_clr, fl_q, mask_q;
  logic          cnt_tgl, sh_ld;

  function automatic logic hit(input logic [2:0] a, input reg_addr_e r);
    return a == r;
  endfunction

  atb_wr_xfer #(.W(CW)) u_cmpa (.cpu_clk, .tmr_clk, .rst_n,
    .wr_i(wr_en_i && hit(addr_i, A_CMPA)), .wdata_i(wdata_i),
    .stage_o(cmpa_stg), .busy_o(busy[0]), .dst_o(cmpa_t));
  atb_wr_xfer #(.W(CW)) u_cmpb (.cpu_clk, .tmr_clk, .rst_n,
    .wr_i(wr_en_i && hit(addr_i, A_CMPB)), .wdata_i(wdata_i),
    .stage_o(cmpb_stg), .busy_o(busy[1]), .dst_o(cmpb_t));
  atb_wr_xfer #(.W(2)) u_ctla (.cpu_clk, .tmr_clk, .rst_n,
    .wr_i(wr_en_i && hit(addr_i, A_CTLA)), .wdata_i(wdata_i[1:0]),
    .stage_o(ctla_stg), .busy_o(busy[2]), .dst_o(ctla_t));
  atb_wr_xfer #(.W(1)) u_ctlb (.cpu_clk, .tmr_clk, .rst_n,
    .wr_i(wr_en_i && hit(addr_i, A_CTLB)), .wdata_i(wdata_i[0]),
    .stage_o(ctlb_stg), .busy_o(busy[3]), .dst_o(ctlb_t));

  atb_tmr_core #(.CW(CW)) u_core (
    .tmr_clk, .rst_n,
    .run_i(ctla_t[CTLA_RUN]), .tga_i(ctla_t[CTLA_TGA]), .tgb_i(ctlb_t),
    .cmpa_i(cmpa_t), .cmpb_i(cmpb_t),
    .cnt_o(cnt_t), .cnt_tgl_o(cnt_tgl), .ev_tgl_o(ev_tgl),
    .pin_a_o, .pin_b_o, .wake_o);

  // shadow count: reloaded after every timer edge has crossed over
  atb_toggle_sync u_shs (.clk_i(cpu_clk), .rst_ni(rst_n), .tgl_i(cnt_tgl), .pulse_o(sh_ld));

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n)     shadow_q <= '0;
    else if (sh_ld) shadow_q <= cnt_t;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_flag
      atb_toggle_sync u_fs (.clk_i(cpu_clk), .rst_ni(rst_n), .tgl_i(ev_tgl[gi]), .pulse_o(fl_set[gi]));
      assign fl_clr[gi] = wr_en_i && hit(addr_i, A_FLAG) && wdata_i[gi];
      always_ff @(posedge cpu_clk or negedge rst_n) begin
        if (!rst_n) fl_q[gi] <= 1'b0;
        else        fl_q[gi] <= fl_set[gi] | (fl_q[gi] & ~fl_clr[gi]);
      end
    end
  endgenerate

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n)                                mask_q <= '0;
    else if (wr_en_i && hit(addr_i, A_MASK))   mask_q <= wdata_i[NFLAG-1:0];
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      A_CNT:   rd_data_o = shadow_q;
      A_CMPA:  rd_data_o = cmpa_stg;
      A_CMPB:  rd_data_o = cmpb_stg;
      A_CTLA:  rd_data_o = CW'(ctla_stg);
      A_CTLB:  rd_data_o = CW'(ctlb_stg);
      A_MASK:  rd_data_o = CW'(mask_q);
      A_FLAG:  rd_data_o = CW'(fl_q);
      default: rd_data_o = CW'(busy);
    endcase
  end

  assign irq_o = gie_i && |(mask_q & fl_q);

  a_r7_flag_a_with_count: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    fl_set[FL_CMPA] |-> sh_ld);
  a_r7_flag_b_with_count: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    fl_set[FL_CMPB] |-> sh_ld);
  a_r9_set_beats_clear: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (fl_set[FL_CMPA] && fl_clr[FL_CMPA]) |=> fl_q[FL_CMPA]);
endmodule

// File: tb/async_tmr_bridge_test.sv
module async_tmr_bridge_test;
  logic cpu_clk = 1'b0, tmr_clk = 1'b0, gate = 1'b0;
  logic rst_n, gie_i, wr_en_i;
  logic [2:0] addr_i;
  logic [7:0] wdata_i, rd_data_o;
  logic irq_o, wake_o, pin_a_o, pin_b_o;
  int n_vec = 0, n_fail = 0;

  typedef struct { int kind; int a; int e; string tag; } item_t;
  item_t sb_q[$];

  async_tmr_bridge uut (.cpu_clk, .tmr_clk, .rst_n, .gie_i, .wr_en_i, .addr_i,
    .wdata_i, .rd_data_o, .irq_o, .wake_o, .pin_a_o, .pin_b_o);

  always begin #4; if (!gate) cpu_clk = ~cpu_clk; end
  initial begin #50; forever begin tmr_clk = 1'b1; #50; tmr_clk = 1'b0; #50; end end

  task automatic chk(input logic ok, input int act, input int exp, input string tag);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per processor cycle
  initial forever begin
    @(posedge cpu_clk); #2;
    if (sb_q.size() > 0) begin
      item_t it = sb_q.pop_front();
      int act = (it.kind == 0) ? int'(rd_data_o) : int'(irq_o);
      chk(act == it.e, act, it.e, it.tag);
    end
  end

  task automatic expect_rd(input int a, input int e, input string tag);
    item_t it;
    @(negedge cpu_clk);
    addr_i = a[2:0];
    it.kind = 0; it.a = a; it.e = e & 8'hFF; it.tag = tag;
    sb_q.push_back(it);
    @(negedge cpu_clk);
  endtask

  task automatic expect_irq(input int e, input string tag);
    item_t it;
    @(negedge cpu_clk);
    it.kind = 1; it.a = 0; it.e = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge cpu_clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge cpu_clk);
    wr_en_i = 1'b1; addr_i = a[2:0]; wdata_i = d[7:0];
    @(negedge cpu_clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge cpu_clk);
    addr_i = a[2:0];
    #1 v = rd_data_o;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] b;
    for (int i = 0; i < 500; i++) begin
      rd(7, b);
      if (b == 8'h00) return;
    end
    chk(1'b0, b, 0, tag);
  endtask

  task automatic align();
    @(posedge tmr_clk);
    repeat (5) @(negedge cpu_clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, c, x;
    logic pa0, pb0;
    rst_n = 1'b0; gie_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    #205 rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) expect_rd(a, 0, "R1");
    expect_irq(0, "R1");
    chk(pin_a_o == 1'b0, pin_a_o, 0, "R1");
    chk(pin_b_o == 1'b0, pin_b_o, 0, "R1");

    // R6: enable register width
    wr(5, 8'hFF); expect_rd(5, 8'h07, "R6");
    wr(5, 8'h00); expect_rd(5, 8'h00, "R6");

    // R4: busy set then cleared
    wr(1, 8'h40); expect_rd(7, 8'h01, "R4");
    wait_idle("R4"); expect_rd(7, 0, "R4"); expect_rd(1, 8'h40, "R4");

    // R5: second write while busy is dropped
    wr(2, 8'h11); wr(2, 8'h22);
    wait_idle("R5"); expect_rd(2, 8'h11, "R5");
    wr(2, 8'hC0); wait_idle("R5"); expect_rd(2, 8'hC0, "R5");

    // R2: start counting, pin A and pin B toggling enabled
    wr(3, 8'h03); wait_idle("R2");
    wr(4, 8'h01); wait_idle("R2");
    align(); rd(0, v);
    repeat (10) @(posedge tmr_clk);
    repeat (5) @(negedge cpu_clk);
    expect_rd(0, v + 10, "R2");

    // R7 R9 R11 R12: compare A match with a colliding clear
    align(); rd(0, v);
    x = v + 8'd12;
    wr(1, x); wait_idle("R7");
    wr(6, 8'h07);
    for (int i = 0; i < 40; i++) begin
      align(); rd(0, c);
      if (c == x - 8'd1) break;
    end
    pa0 = pin_a_o;
    @(posedge tmr_clk);
    fork
      begin
        @(negedge tmr_clk);
        chk(pin_a_o != pa0, pin_a_o, !pa0, "R11");
        chk(wake_o == 1'b0, wake_o, 0, "R12");
        @(negedge tmr_clk);
        chk(wake_o == 1'b1, wake_o, 1, "R12");
        @(negedge tmr_clk);
        chk(wake_o == 1'b0, wake_o, 0, "R12");
      end
      begin
        @(posedge cpu_clk); @(posedge cpu_clk);
        @(negedge cpu_clk);
        wr_en_i = 1'b1; addr_i = 3'd6; wdata_i = 8'h02;
        @(negedge cpu_clk);
        wr_en_i = 1'b0;
      end
    join
    expect_rd(6, 8'h02, "R9");

    // R10: interrupt gating with flag A set
    gie_i = 1'b1; expect_irq(0, "R10");
    wr(5, 8'h02); gie_i = 1'b0; expect_irq(0, "R10");
    gie_i = 1'b1; expect_irq(1, "R10");
    wr(6, 8'h02); expect_rd(6, 0, "R9"); expect_irq(0, "R10");
    gie_i = 1'b0; wr(5, 0);

    // R7: compare B flag appears together with the matching count
    align(); rd(0, v);
    x = v + 8'd12;
    wr(2, x); wait_idle("R7");
    wr(6, 8'h07);
    pb0 = pin_b_o;
    c = v;
    for (int i = 0; i < 3000 && c != x; i++) rd(0, c);
    chk(c == x, c, x, "R7");
    rd(6, v);
    chk(v[2] == 1'b1, v, 8'h04, "R7");
    chk(pin_b_o != pb0, pin_b_o, !pb0, "R11");

    // R8: overflow flag, count reads zero at that moment
    wr(6, 8'h07);
    v = '0;
    for (int i = 0; i < 4000 && !v[0]; i++) rd(6, v);
    chk(v[0] == 1'b1, v, 1, "R8");
    expect_rd(0, 0, "R8");
    wr(5, 8'h01); gie_i = 1'b1; expect_irq(1, "R10");
    wr(6, 8'h01); expect_irq(0, "R10");
    gie_i = 1'b0;

    // R3: stopped processor clock leaves a stale shadow
    align(); rd(0, v);
    @(negedge cpu_clk); gate = 1'b1;
    repeat (5) @(posedge tmr_clk);
    #20 gate = 1'b0;
    expect_rd(0, v, "R3");
    align();
    expect_rd(0, v + 6, "R3");

    repeat (4) @(negedge cpu_clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule